// File: doc/BRIEF.md
# Sparse PAM-4 Transmit Tap Generator

This block is the digital front end of a four-tap sparse FIR equalizer for a PAM-4 transmitter. It accepts one 2-bit symbol per clock and keeps a short history of past symbols. From that history it picks four tap symbols:

- a precursor tap, which holds the symbol one interval newer than the main one;
- the main cursor;
- a postcursor tap, which holds the symbol one interval older than the main one;
- a movable "rover" tap, which can sit 2 to 8 intervals after the main cursor.

Each tap symbol leaves the block as a 3-bit thermometer word that drives the columns of a current-steering DAC cell.

Each tap also has a 6-bit saturating weight counter. The far-end receiver steps these counters up or down with adjust commands while the link is running, so the equalizer keeps tracking drift in supply, temperature and channel. The analog DACs, the summing node and serialization sit outside this block. Both the weights and the thermometer words are presented as registered outputs.

Top module: `txeq_tapgen`

## Requirements
- R1: While `rst` is high at a clock edge, every thermometer word becomes 000, the rover position becomes 2, the main-cursor weight becomes 32 and the other three weights become 0.
- R2: Tap slot 0 (`tap_therm[2:0]`) carries the symbol that was on `sym_in` two clock edges before. It is the symbol one interval newer than the main cursor.
- R3: Tap slot 1 (`tap_therm[5:3]`) is the main cursor. It carries the symbol sampled three edges before, which is the value slot 0 held one cycle earlier.
- R4: Tap slot 2 (`tap_therm[8:6]`) carries the symbol sampled four edges before, one interval older than the main cursor.
- R5: Tap slot 3 (`tap_therm[11:9]`) carries the symbol that is P intervals older than the main cursor, where P is in the range 2..8. P is taken from `rover_pos` at one edge and is used by the output register at the next edge.
- R6: A `rover_pos` value below 2 acts as 2, and a value above 8 acts as 8.
- R7: The thermometer code maps symbol 0 to 000, 1 to 001, 2 to 011 and 3 to 111, written as bits [2:0] of each 3-bit field.
- R8: When `adj_valid` is high at an edge, the weight selected by `adj_tap` (0 to 3, the same slot order as the tap words) goes up by one if `adj_up` is 1 and down by one if it is 0. The change is visible right after that edge. The other weights do not change, and no weight changes when `adj_valid` is low.
- R9: A weight at 63 stays at 63 when it receives an up command.
- R10: A weight at 0 stays at 0 when it receives a down command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_in | input | 2 | PAM-4 symbol entering the history |
| rover_pos | input | 4 | Requested rover offset from the main cursor |
| adj_valid | input | 1 | Strobe for one weight adjust command |
| adj_tap | input | 2 | Slot index of the weight to adjust |
| adj_up | input | 1 | 1 steps the weight up, 0 steps it down |
| tap_therm | output | 12 | Four 3-bit thermometer words, slot t at [3t+2:3t] |
| tap_coef | output | 24 | Four 6-bit weights, slot t at [6t+5:6t] |

## Verification
The bench drives a pseudo-random symbol stream and sweeps every `rover_pos` code from 0 to 15. It first holds each code for many cycles and then changes the code on every cycle. A design with an off-by-one in the history index, or with an unclamped position, would put the wrong symbol on the rover slot or read past the end of the history. Long runs of up commands followed by long runs of down commands push every weight against both rails, which exposes counters that wrap from 63 to 0 or from 0 to 63. A final random mix of commands checks that a command reaches only its own weight. It also checks that a weight moves on the edge that samples the strobe, not one edge later.

// File: rtl/txeq_pkg.sv
package txeq_pkg;
  localparam int NTAP    = 4;
  localparam int SYM_W   = 2;
  localparam int THERM_W = (1 << SYM_W) - 1;

  typedef enum logic [1:0] {
    SLOT_PRE   = 2'd0,
    SLOT_MAIN  = 2'd1,
    SLOT_POST  = 2'd2,
    SLOT_ROVER = 2'd3
  } slot_e;
endpackage

// File: rtl/txeq_hist.sv
module txeq_hist #(
  parameter int SYM_W     = 2,
  parameter int POS_W     = 4,
  parameter int ROVER_MIN = 2,
  parameter int ROVER_MAX = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SYM_W-1:0]   sym_in,
  input  logic [POS_W-1:0]   pos_in,
  output logic [SYM_W-1:0]   pre_sym,
  output logic [SYM_W-1:0]   main_sym,
  output logic [SYM_W-1:0]   post_sym,
  output logic [SYM_W-1:0]   rover_sym
);
  localparam int DEPTH = ROVER_MAX + 2;
  localparam logic [POS_W-1:0] PMIN = POS_W'(ROVER_MIN);
  localparam logic [POS_W-1:0] PMAX = POS_W'(ROVER_MAX);

  logic [SYM_W-1:0] line_q [DEPTH];
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
      pos_q <= PMIN;
    end else begin
      line_q[0] <= sym_in;
      for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
      if (pos_in < PMIN)      pos_q <= PMIN;
      else if (pos_in > PMAX) pos_q <= PMAX;
      else                    pos_q <= pos_in;
    end
  end

  assign pre_sym  = line_q[0];
  assign main_sym = line_q[1];
  assign post_sym = line_q[2];

  always_comb begin
    rover_sym = '0;
    for (int i = 0; i < DEPTH; i++)
      if (POS_W'(i) == pos_q + POS_W'(1)) rover_sym = line_q[i];
  end

  // R6: the held rover position never leaves the legal window
  assert_pos_window_R6: assert property (@(posedge clk) disable iff (rst)
    (pos_q >= PMIN) && (pos_q <= PMAX));
endmodule

// File: rtl/txeq_therm.sv
module txeq_therm #(
  parameter int SYM_W = 2,
  localparam int TW   = (1 << SYM_W) - 1
) (
  input  logic [SYM_W-1:0] sym,
  output logic [TW-1:0]    therm
);
  always_comb begin
    for (int b = 0; b < TW; b++)
      therm[b] = ({1'b0, sym} > (SYM_W+1)'(b));
  end
endmodule

// File: rtl/txeq_coef.sv
module txeq_coef #(
  parameter int COEF_W = 6,
  parameter int INIT   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_up,
  input  logic              step_dn,
  output logic [COEF_W-1:0] coef
);
  localparam logic [COEF_W-1:0] CMAX  = '1;
  localparam logic [COEF_W-1:0] CINIT = COEF_W'(INIT);

  always_ff @(posedge clk) begin
    if (rst)                          coef <= CINIT;
    else if (step_up && coef != CMAX) coef <= coef + 1'b1;
    else if (step_dn && coef != '0)   coef <= coef - 1'b1;
  end

  assert_no_wrap_hi_R9: assert property (@(posedge clk) disable iff (rst)
    (coef == CMAX && step_up) |=> (coef == CMAX));
  assert_no_wrap_lo_R10: assert property (@(posedge clk) disable iff (rst)
    (coef == '0 && step_dn) |=> (coef == '0));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!step_up && !step_dn) |=> $stable(coef));
endmodule

// File: rtl/txeq_tapgen.sv
module txeq_tapgen #(
  parameter int COEF_W    = 6,
  parameter int MAIN_INIT = 32,
  parameter int POS_W     = 4,
  parameter int ROVER_MIN = 2,
  parameter int ROVER_MAX = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [1:0]                        sym_in,
  input  logic [POS_W-1:0]                  rover_pos,
  input  logic                              adj_valid,
  input  logic [1:0]                        adj_tap,
  input  logic                              adj_up,
  output logic [txeq_pkg::NTAP*3-1:0]       tap_therm,
  output logic [txeq_pkg::NTAP*COEF_W-1:0]  tap_coef
);
  import txeq_pkg::*;

  logic [SYM_W-1:0]   slot_sym [NTAP];
  logic [THERM_W-1:0] slot_th  [NTAP];

  txeq_hist #(
    .SYM_W(SYM_W), .POS_W(POS_W),
    .ROVER_MIN(ROVER_MIN), .ROVER_MAX(ROVER_MAX)
  ) u_hist (
    .clk(clk), .rst(rst), .sym_in(sym_in), .pos_in(rover_pos),
    .pre_sym(slot_sym[SLOT_PRE]), .main_sym(slot_sym[SLOT_MAIN]),
    .post_sym(slot_sym[SLOT_POST]), .rover_sym(slot_sym[SLOT_ROVER])
  );

  for (genvar t = 0; t < NTAP; t++) begin : g_slot
    logic up_t, dn_t;
    assign up_t = adj_valid &&  adj_up && (adj_tap == 2'(t));
    assign dn_t = adj_valid && !adj_up && (adj_tap == 2'(t));

    txeq_therm #(.SYM_W(SYM_W)) u_th (.sym(slot_sym[t]), .therm(slot_th[t]));

    txeq_coef #(
      .COEF_W(COEF_W),
      .INIT((t == int'(SLOT_MAIN)) ? MAIN_INIT : 0)
    ) u_coef (
      .clk(clk), .rst(rst), .step_up(up_t), .step_dn(dn_t),
      .coef(tap_coef[t*COEF_W +: COEF_W])
    );

    always_ff @(posedge clk) begin
      if (rst) tap_therm[t*THERM_W +: THERM_W] <= '0;
      else     tap_therm[t*THERM_W +: THERM_W] <= slot_th[t];
    end

    // R7: every emitted word is a legal thermometer code
    assert_therm_legal_R7: assert property (@(posedge clk) disable iff (rst)
      (!tap_therm[t*THERM_W+2] || tap_therm[t*THERM_W+1]) &&
      (!tap_therm[t*THERM_W+1] || tap_therm[t*THERM_W]));
  end

  // R3: the main cursor repeats what the precursor slot showed one cycle earlier
  assert_main_follows_pre_R3: assert property (@(posedge clk) disable iff (rst)
    tap_therm[5:3] == $past(tap_therm[2:0]));
  // R4: the postcursor repeats what the main slot showed one cycle earlier
  assert_post_follows_main_R4: assert property (@(posedge clk) disable iff (rst)
    tap_therm[8:6] == $past(tap_therm[5:3]));
endmodule

// File: tb/sim_txeq_tapgen.sv
module sim_txeq_tapgen;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC = 2400;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  sym_in;
  logic [3:0]  rover_pos;
  logic        adj_valid;
  logic [1:0]  adj_tap;
  logic        adj_up;
  logic [11:0] tap_therm;
  logic [23:0] tap_coef;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int sent [16];
  int posh [2];
  int cm   [4];
  int lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  txeq_tapgen u0 (
    .clk(clk), .rst(rst), .sym_in(sym_in), .rover_pos(rover_pos),
    .adj_valid(adj_valid), .adj_tap(adj_tap), .adj_up(adj_up),
    .tap_therm(tap_therm), .tap_coef(tap_coef)
  );

  function automatic int enc(int s);
    return ((s >= 3) ? 4 : 0) + ((s >= 2) ? 2 : 0) + ((s >= 1) ? 1 : 0);
  endfunction

  function automatic int clampp(int p);
    return (p < 2) ? 2 : ((p > 8) ? 8 : p);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic next_rand();
    lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
  endtask

  task automatic check_all(int raw_pos);
    int p;
    p = posh[1];
    chk("R2 R7 precursor slot", int'(tap_therm[2:0]), enc(sent[1]));
    chk("R3 R7 main slot", int'(tap_therm[5:3]), enc(sent[2]));
    chk("R4 R7 postcursor slot", int'(tap_therm[8:6]), enc(sent[3]));
    if (raw_pos < 2 || raw_pos > 8)
      chk("R6 R5 rover slot clamped", int'(tap_therm[11:9]), enc(sent[2+p]));
    else
      chk("R5 rover slot", int'(tap_therm[11:9]), enc(sent[2+p]));
    for (int t = 0; t < 4; t++) begin
      if (cm[t] == 63)     chk("R9 weight upper rail", int'(tap_coef[t*6 +: 6]), cm[t]);
      else if (cm[t] == 0) chk("R10 weight lower rail", int'(tap_coef[t*6 +: 6]), cm[t]);
      else                 chk("R8 weight value", int'(tap_coef[t*6 +: 6]), cm[t]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int raw_prev;
    rst = 1'b1; sym_in = 2'd0; rover_pos = 4'd2;
    adj_valid = 1'b0; adj_tap = 2'd0; adj_up = 1'b0;
    for (int i = 0; i < 16; i++) sent[i] = 0;
    posh[0] = 2; posh[1] = 2;
    cm[0] = 0; cm[1] = 32; cm[2] = 0; cm[3] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 thermometer words after reset", int'(tap_therm), 0);
    chk("R1 precursor weight", int'(tap_coef[5:0]), 0);
    chk("R1 main weight", int'(tap_coef[11:6]), 32);
    chk("R1 postcursor weight", int'(tap_coef[17:12]), 0);
    chk("R1 rover weight", int'(tap_coef[23:18]), 0);
    rst = 1'b0;
    raw_prev = 2;
    for (int n = 0; n < NCYC; n++) begin
      int s, rp, tp, up, vl;
      if (n > 0) begin
        @(negedge clk);
        check_all(raw_prev);
      end
      next_rand();
      s  = lfsr & 3;
      rp = (n < 1800) ? ((n / 60) % 16) : (((lfsr >> 4) & 15) ^ (n % 16));
      if (n < 400)      begin vl = 1; tp = n % 4; up = 1; end
      else if (n < 800) begin vl = 1; tp = n % 4; up = 0; end
      else begin vl = (lfsr >> 8) & 1; tp = (lfsr >> 9) & 3; up = (lfsr >> 11) & 1; end
      for (int i = 15; i > 0; i--) sent[i] = sent[i-1];
      sent[0] = s;
      posh[1] = posh[0];
      posh[0] = clampp(rp);
      raw_prev = (posh[1] == 2 || posh[1] == 8) ? raw_prev : rp;
      raw_prev = rp;
      if (vl == 1) begin
        if (up == 1 && cm[tp] < 63) cm[tp]++;
        else if (up == 0 && cm[tp] > 0) cm[tp]--;
      end
      sym_in = 2'(s); rover_pos = 4'(rp);
      adj_valid = vl[0]; adj_tap = 2'(tp); adj_up = up[0];
    end
    @(negedge clk);
    check_all(raw_prev);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule